// File: doc/BRIEF.md
# Second-Operand Shifter

This block reshapes the second source operand of an arithmetic or logic unit before that operand reaches the adder or the logic gates. It is purely combinational. It takes a data word, a three-bit shift kind, a shift amount from 0 to DATA_W-1 and the current carry flag. It returns the reshaped word and a shifter carry that logical instructions may write into the flag register. The first operand never passes through this block, so the shifter sits on one ALU input only.

Five shift kinds are supported:

- left shift, which also serves as the arithmetic left shift;
- right shift with zero fill;
- right shift with sign fill;
- right rotation;
- a single-step right rotation through the carry flag, which behaves as a (DATA_W+1)-bit rotate.

Kind codes that are not assigned leave the operand and the flag untouched.

Top module: `operand_shifter`

## Requirements
- R1: Kind 0 (left shift) by n gives the operand shifted toward the MSB by n, with the n lowest bits set to zero.
- R2: Kind 1 (logical right shift) by n gives the operand shifted toward the LSB by n, with the n highest bits set to zero.
- R3: Kind 2 (arithmetic right shift) by n fills the n highest bits with copies of the operand's original bit DATA_W-1.
- R4: Kind 3 (rotate) by n moves each bit i to position (i-n) mod DATA_W, so bits leaving bit 0 re-enter at the top.
- R5: Kind 4 (rotate through carry) gives {carry_i, op_i[DATA_W-1:1]} and carry_o = op_i[0], whatever amt_i is.
- R6: For kinds 0, 1, 2, 3 and 5, an amount of 0 passes the operand unchanged and carry_o equals carry_i.
- R7: For kinds 0, 1, 2, 3 and 5 with amount n > 0, carry_o is the last bit shifted out. For a left shift this is op_i[DATA_W-n]; for the right kinds it is op_i[n-1].
- R8: Kind codes 6 and 7 give result_o = op_i and carry_o = carry_i.
- R9: Kind 5 (arithmetic left shift) gives exactly the same result and carry as kind 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | DATA_W | Second source operand |
| kind_i | input | 3 | Shift kind code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX, 5 ASL) |
| amt_i | input | $clog2(DATA_W) | Shift amount, 0 to DATA_W-1 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | DATA_W | Reshaped operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench applies every kind at amounts 0, 1, 16 and 31, using operands with the sign bit clear and with it set, under both carry values. It then adds a random sweep.

Several faults are aimed at directly:

- A right shift that fills from the wrong source shows up as stray ones in a logical shift, or as zeros in an arithmetic shift of a negative word.
- A rotate that drops the wrapped bits loses ones at the top.
- A carry taken one position off, or left untouched at amount 0, disagrees with the flag the model expects.
- A rotate through carry that honours amt_i, or that drops the incoming flag, gives a wrong bit 31.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4,
    SK_ASL = 3'd5
  } shift_kind_e;
endpackage

// File: rtl/opsh_left.sv
module opsh_left #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  localparam logic [AMT_W:0] W_L = (AMT_W+1)'(DATA_W);

  logic [DATA_W-1:0] stg [AMT_W+1];
  logic [AMT_W:0]    idx;

  assign stg[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt_i[k] ? (stg[k] << S) : stg[k];
  end

  assign res_o  = stg[AMT_W];
  assign idx    = W_L - {1'b0, amt_i};
  // last bit shifted out; index only valid for amt > 0
  assign cout_o = (amt_i == '0) ? 1'b0 : data_i[idx[AMT_W-1:0]];

  always_comb begin
    if (!$isunknown(amt_i) && !$isunknown(res_o) && amt_i != '0) begin
      a_r1_lsl_lsb_zero: assert (res_o[0] == 1'b0)
        else $error("left shift left a one in bit 0");
    end
  end
endmodule

// File: rtl/opsh_right.sv
module opsh_right #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              sign_fill_i,
  input  logic              rotate_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  logic [DATA_W-1:0] stg [AMT_W+1];
  logic [AMT_W-1:0]  idx;
  logic              fill_bit;

  assign stg[0]   = data_i;
  assign fill_bit = sign_fill_i & data_i[DATA_W-1];

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0] fill;
    assign fill     = rotate_i ? stg[k][S-1:0] : {S{fill_bit}};
    assign stg[k+1] = amt_i[k] ? {fill, stg[k][DATA_W-1:S]} : stg[k];
  end

  assign res_o  = stg[AMT_W];
  assign idx    = amt_i - AMT_W'(1);
  assign cout_o = (amt_i == '0) ? 1'b0 : data_i[idx];

  always_comb begin
    if (!$isunknown({amt_i, sign_fill_i, rotate_i, data_i, res_o}) && amt_i != '0) begin
      if (!sign_fill_i && !rotate_i) begin
        a_r2_lsr_msb_zero: assert (res_o[DATA_W-1] == 1'b0)
          else $error("logical right shift set the top bit");
      end
      if (sign_fill_i && !rotate_i) begin
        a_r3_asr_sign_kept: assert (res_o[DATA_W-1] == data_i[DATA_W-1])
          else $error("arithmetic right shift lost the sign");
      end
    end
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opsh_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] op_i,
  input  logic [2:0]        kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  shift_kind_e       kind;
  logic [DATA_W-1:0] left_res, right_res;
  logic              left_c, right_c;
  logic              amt_zero;

  assign kind     = shift_kind_e'(kind_i);
  assign amt_zero = (amt_i == '0);

  opsh_left #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_left (
    .data_i (op_i),
    .amt_i  (amt_i),
    .res_o  (left_res),
    .cout_o (left_c)
  );

  opsh_right #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_right (
    .data_i      (op_i),
    .amt_i       (amt_i),
    .sign_fill_i (kind == SK_ASR),
    .rotate_i    (kind == SK_ROR),
    .res_o       (right_res),
    .cout_o      (right_c)
  );

  always_comb begin
    result_o = op_i;
    carry_o  = carry_i;
    case (kind)
      SK_LSL, SK_ASL: begin
        result_o = left_res;
        carry_o  = amt_zero ? carry_i : left_c;
      end
      SK_LSR, SK_ASR, SK_ROR: begin
        result_o = right_res;
        carry_o  = amt_zero ? carry_i : right_c;
      end
      SK_RRX: begin
        result_o = {carry_i, op_i[DATA_W-1:1]};
        carry_o  = op_i[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, kind_i, amt_i, carry_i, result_o, carry_o})) begin
      if (amt_zero && kind_i != 3'd4 && kind_i < 3'd6) begin
        a_r6_zero_pass: assert (result_o == op_i && carry_o == carry_i)
          else $error("zero amount altered operand or flag");
      end
      if (kind_i == 3'd3) begin
        a_r4_rot_keeps_ones: assert ($countones(result_o) == $countones(op_i))
          else $error("rotate changed the number of ones");
      end
      if (kind_i == 3'd4) begin
        a_r5_rrx_keeps_ones: assert (($countones(result_o) + 32'(carry_o)) ==
                                     ($countones(op_i) + 32'(carry_i)))
          else $error("carry rotate lost or gained a one");
      end
      if (kind_i >= 3'd6) begin
        a_r8_spare_kind_pass: assert (result_o == op_i && carry_o == carry_i)
          else $error("spare kind code altered operand");
      end
    end
  end
endmodule

// File: tb/operand_shifter_bench.sv
module operand_shifter_bench;
  logic        clk = 1'b0;
  logic [31:0] op_s = '0;
  logic [2:0]  kind_s = '0;
  logic [4:0]  amt_s = '0;
  logic        cin_s = 1'b0;
  logic [31:0] res_w;
  logic        cout_w;
  int          total = 0;
  int          bad = 0;
  logic        done = 1'b0;

  always #4ns clk = ~clk;

  operand_shifter u_operand_shifter (
    .op_i     (op_s),
    .kind_i   (kind_s),
    .amt_i    (amt_s),
    .carry_i  (cin_s),
    .result_o (res_w),
    .carry_o  (cout_w)
  );

  function automatic void model(input logic [31:0] op, input int kind, input int n,
                                input logic cin, output logic [31:0] r, output logic c);
    r = op;
    c = cin;
    case (kind)
      0, 5: if (n > 0) begin
        for (int i = 0; i < 32; i++) r[i] = (i >= n) ? op[i-n] : 1'b0;
        c = op[32-n];
      end
      1, 2: if (n > 0) begin
        for (int i = 0; i < 32; i++)
          r[i] = (i + n < 32) ? op[i+n] : ((kind == 2) ? op[31] : 1'b0);
        c = op[n-1];
      end
      3: if (n > 0) begin
        for (int i = 0; i < 32; i++) r[i] = op[(i+n)%32];
        c = op[n-1];
      end
      4: begin
        for (int i = 0; i < 31; i++) r[i] = op[i+1];
        r[31] = cin;
        c = op[0];
      end
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input int kind, input int n);
    if (kind == 4) return "R5";
    if (kind >= 6) return "R8";
    if (n == 0) return "R6";
    if (kind == 5) return "R9";
    case (kind)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic [31:0] op, input int kind, input int n, input logic cin);
    logic [31:0] exp_r;
    logic        exp_c;
    string       t, tc;
    @(posedge clk);
    #2ns;
    op_s   = op;
    kind_s = kind[2:0];
    amt_s  = n[4:0];
    cin_s  = cin;
    @(negedge clk);
    model(op, kind, n, cin, exp_r, exp_c);
    t  = tag_of(kind, n);
    tc = (n > 0 && kind != 4 && kind < 6) ? "R7" : t;
    total++;
    if (res_w !== exp_r) begin
      bad++;
      $display("FAIL %s result kind=%0d n=%0d op=%h cin=%0b: got %h exp %h",
               t, kind, n, op, cin, res_w, exp_r);
    end
    total++;
    if (cout_w !== exp_c) begin
      bad++;
      $display("FAIL %s carry kind=%0d n=%0d op=%h cin=%0b: got %0b exp %0b",
               tc, kind, n, op, cin, cout_w, exp_c);
    end
  endtask

  initial begin
    logic [31:0] ops [4];
    int          amts [4];
    logic [31:0] lcg;
    ops[0] = 32'h8000_0001;
    ops[1] = 32'h7FFF_FFFE;
    ops[2] = 32'hA5C3_0F96;
    ops[3] = 32'h1234_5678;
    amts[0] = 0; amts[1] = 1; amts[2] = 16; amts[3] = 31;
    // idle inputs: all zero in, zero out (R6)
    apply(32'h0, 0, 0, 1'b0);
    for (int k = 0; k < 8; k++)
      for (int o = 0; o < 4; o++)
        for (int a = 0; a < 4; a++)
          for (int c = 0; c < 2; c++)
            apply(ops[o], k, amts[a], c[0]);
    // R5: amount ignored for carry rotate
    apply(32'hFFFF_FFFF, 4, 13, 1'b0);
    apply(32'h0000_0000, 4, 7, 1'b1);
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      apply({lcg[15:0], lcg[31:16]} ^ lcg, int'(lcg[26:24]), int'(lcg[12:8]), lcg[3]);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule